// File: doc/BRIEF.md
# Dual-Channel Bus Transceiver Mode Controller

This block holds the digital mode logic of a two-channel differential bus transceiver. Each channel has its own standby request input and settles in one of four named states: `CH_OFF` (fully disengaged), `CH_STBY` (low-power listening), `CH_WAKING` (Standby-to-Normal transition delay) and `CH_NORM` (transmit and receive active). From the state it drives, per channel, a transmitter enable, a normal-receiver enable, a low-power-receiver enable, a two-bit bus-bias select and the receive data output.

Two supply-monitor flags arrive as synchronous inputs. A core-supply undervoltage flag pushes both channels back to Standby and masks their requests until it clears. An I/O-supply undervoltage flag drops both channels to `CH_OFF` with zero bus load. The Standby-to-Normal delay is a count of clock cycles held in a parameter.

The transitions are: `CH_STBY -> CH_WAKING` when the request is low and the core supply is good. `CH_WAKING -> CH_NORM` when the delay count completes. `CH_WAKING -> CH_STBY` and `CH_NORM -> CH_STBY` when the request goes high or the core supply fails. Any state goes to `CH_OFF` on an I/O-supply fault. `CH_OFF -> CH_STBY` when that fault clears.

Top module: `dual_xcvr_mode_ctrl`

## Requirements
- R1: Each channel follows only its own standby request (0 = go to Normal, 1 = stay in Standby). A request on one channel leaves the other channel's outputs unchanged.
- R2: In Standby (and during the transition delay), the channel outputs are as follows: `tx_en`=0, `nrx_en`=0, `lprx_en`=1, and the bias field is 2'b01 (bus tied to ground).
- R3: In Normal mode the channel outputs are `tx_en`=1, `nrx_en`=1, `lprx_en`=0, with the bias field at 2'b10 (mid-supply). `rx_out` is the inverse of `bus_dom` (0 when the bus is dominant, 1 when recessive).
- R4: In Standby, `rx_out` is 0 while the channel's `wake_det` is 1, and 1 otherwise.
- R5: A wake detection alone never moves a channel out of Standby while its request is 1.
- R6: While `core_uv` is 1, both channels show Standby outputs from the next clock edge on, whatever their requests. After it clears, a low request starts a full transition delay.
- R7: While `io_uv` is 1, both channels show the following from the next edge on: all three enables 0, bias field 2'b00 (floating, zero load) and `rx_out`=1. On the first edge after the flag clears, they return to Standby outputs.
- R8: `tx_en` rises on the (DLY_CYC+1)-th rising edge that samples the request low. If the request is high at any edge in between, the count restarts from zero.
- R9: After reset both channels show Standby outputs, with the transmitter and normal receiver disabled.
- The bias field of channel i is `bias_sel[2*i+1:2*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stby_req | input | NCH | Per-channel standby request, 1 = Standby |
| bus_dom | input | NCH | Per-channel normal-receiver result, 1 = bus dominant |
| wake_det | input | NCH | Per-channel wake-up detected flag from the low-power receiver |
| core_uv | input | 1 | Core-supply undervoltage flag |
| io_uv | input | 1 | I/O-supply undervoltage flag |
| tx_en | output | NCH | Transmitter enable |
| nrx_en | output | NCH | Normal-receiver enable |
| lprx_en | output | NCH | Low-power-receiver enable |
| bias_sel | output | 2*NCH | Per-channel bias: 00 floating, 01 ground, 10 mid-supply |
| rx_out | output | NCH | Receive data output |

## Verification
The mode logic is driven with the following patterns:
- One channel requests Normal while the other holds Standby. This separates truly independent channels from ones that share state.
- A request is held low through the full delay, and separately raised partway through. Comparing the two at the cycle before and the cycle of `tx_en` rising distinguishes a restarting counter from one that resumes or runs short.
- Bus and wake inputs are toggled in both modes. This shows which source `rx_out` selects in each mode.
- Core-supply and I/O-supply faults are raised with requests low and both bus flags set. This separates "back to Standby with requests masked" from "fully off with output held high".

// File: rtl/xcvr_mode_pkg.sv
package xcvr_mode_pkg;

    typedef enum logic [1:0] {
        CH_OFF    = 2'd0,
        CH_STBY   = 2'd1,
        CH_WAKING = 2'd2,
        CH_NORM   = 2'd3
    } ch_state_e;

    typedef enum logic [1:0] {
        BIAS_FLOAT = 2'b00,
        BIAS_GND   = 2'b01,
        BIAS_MID   = 2'b10
    } bias_e;

endpackage

// File: rtl/xcvr_wake_timer.sv
module xcvr_wake_timer #(
    parameter int DLY_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(DLY_CYC) + 1;
    localparam logic [CW-1:0] LAST = CW'(DLY_CYC - 1);

    logic [CW-1:0] cnt;

    assign done = run && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/xcvr_chan_fsm.sv
module xcvr_chan_fsm
    import xcvr_mode_pkg::*;
#(
    parameter int DLY_CYC = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stby_req,
    input  logic       bus_dom,
    input  logic       wake_det,
    input  logic       core_uv,
    input  logic       io_uv,
    output logic       tx_en,
    output logic       nrx_en,
    output logic       lprx_en,
    output logic [1:0] bias_sel,
    output logic       rx_out
);
    ch_state_e cur, nxt;
    logic      dly_done;

    xcvr_wake_timer #(.DLY_CYC(DLY_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cur == CH_WAKING),
        .done  (dly_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= CH_STBY;
        end else begin
            cur <= nxt;
        end
    end

    always_comb begin
        nxt = cur;
        if (io_uv) begin
            nxt = CH_OFF;
        end else begin
            unique case (cur)
                CH_OFF:    nxt = CH_STBY;
                CH_STBY:   if (!core_uv && !stby_req) nxt = CH_WAKING;
                CH_WAKING: begin
                    if (core_uv || stby_req) nxt = CH_STBY;
                    else if (dly_done)       nxt = CH_NORM;
                end
                CH_NORM:   if (core_uv || stby_req) nxt = CH_STBY;
                default:   nxt = CH_STBY;
            endcase
        end
    end

    always_comb begin
        tx_en    = 1'b0;
        nrx_en   = 1'b0;
        lprx_en  = 1'b0;
        bias_sel = BIAS_FLOAT;
        rx_out   = 1'b1;
        unique case (cur)
            CH_OFF: begin
                rx_out = 1'b1;
            end
            CH_STBY, CH_WAKING: begin
                lprx_en  = 1'b1;
                bias_sel = BIAS_GND;
                rx_out   = ~wake_det;
            end
            CH_NORM: begin
                tx_en    = 1'b1;
                nrx_en   = 1'b1;
                bias_sel = BIAS_MID;
                rx_out   = ~bus_dom;
            end
            default: begin
                rx_out = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/dual_xcvr_mode_ctrl.sv
module dual_xcvr_mode_ctrl #(
    parameter int NCH     = 2,
    parameter int DLY_CYC = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   stby_req,
    input  logic [NCH-1:0]   bus_dom,
    input  logic [NCH-1:0]   wake_det,
    input  logic             core_uv,
    input  logic             io_uv,
    output logic [NCH-1:0]   tx_en,
    output logic [NCH-1:0]   nrx_en,
    output logic [NCH-1:0]   lprx_en,
    output logic [2*NCH-1:0] bias_sel,
    output logic [NCH-1:0]   rx_out
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        xcvr_chan_fsm #(.DLY_CYC(DLY_CYC)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .stby_req (stby_req[i]),
            .bus_dom  (bus_dom[i]),
            .wake_det (wake_det[i]),
            .core_uv  (core_uv),
            .io_uv    (io_uv),
            .tx_en    (tx_en[i]),
            .nrx_en   (nrx_en[i]),
            .lprx_en  (lprx_en[i]),
            .bias_sel (bias_sel[2*i +: 2]),
            .rx_out   (rx_out[i])
        );
    end
endmodule

// File: rtl/dual_xcvr_mode_ctrl_chk.sv
module dual_xcvr_mode_ctrl_chk #(
    parameter int NCH = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCH-1:0]   stby_req,
    input logic [NCH-1:0]   bus_dom,
    input logic [NCH-1:0]   wake_det,
    input logic             core_uv,
    input logic             io_uv,
    input logic [NCH-1:0]   tx_en,
    input logic [NCH-1:0]   nrx_en,
    input logic [NCH-1:0]   lprx_en,
    input logic [2*NCH-1:0] bias_sel,
    input logic [NCH-1:0]   rx_out
);
    AST_IO_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        io_uv |=> (tx_en == '0 && nrx_en == '0 && lprx_en == '0 && bias_sel == '0 && rx_out == '1)); // R7
    AST_CORE_FAULT_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (core_uv && !io_uv) |=> (tx_en == '0 && lprx_en == '1)); // R6

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        AST_TX_RISE_AFTER_LOW_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(tx_en[i]) |-> (!$past(stby_req[i]) && !$past(core_uv))); // R8
        AST_WAKE_KEEPS_STBY: assert property (@(posedge clk) disable iff (!rst_n)
            (stby_req[i] && !tx_en[i]) |=> !tx_en[i]); // R5
        AST_NORM_RX_FOLLOWS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
            tx_en[i] |-> (rx_out[i] == !bus_dom[i] && bias_sel[2*i +: 2] == 2'b10)); // R3
        AST_STBY_BIAS_GND: assert property (@(posedge clk) disable iff (!rst_n)
            lprx_en[i] |-> (bias_sel[2*i +: 2] == 2'b01 && !nrx_en[i] && rx_out[i] == !wake_det[i])); // R2
    end
endmodule

bind dual_xcvr_mode_ctrl dual_xcvr_mode_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stby_req (stby_req),
    .bus_dom  (bus_dom),
    .wake_det (wake_det),
    .core_uv  (core_uv),
    .io_uv    (io_uv),
    .tx_en    (tx_en),
    .nrx_en   (nrx_en),
    .lprx_en  (lprx_en),
    .bias_sel (bias_sel),
    .rx_out   (rx_out)
);

// File: tb/dual_xcvr_mode_ctrl_test.sv
module dual_xcvr_mode_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam int DLY = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] stby_req = '1;
    logic [NCH-1:0] bus_dom = '0;
    logic [NCH-1:0] wake_det = '0;
    logic core_uv = 1'b0;
    logic io_uv = 1'b0;
    logic [NCH-1:0] tx_en, nrx_en, lprx_en, rx_out;
    logic [2*NCH-1:0] bias_sel;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_xcvr_mode_ctrl #(.NCH(NCH), .DLY_CYC(DLY)) uut (
        .clk(clk), .rst_n(rst_n), .stby_req(stby_req), .bus_dom(bus_dom),
        .wake_det(wake_det), .core_uv(core_uv), .io_uv(io_uv),
        .tx_en(tx_en), .nrx_en(nrx_en), .lprx_en(lprx_en),
        .bias_sel(bias_sel), .rx_out(rx_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // packed {tx,nrx,lprx,bias[1:0]}
    function automatic int ch_view(input int ch);
        return {tx_en[ch], nrx_en[ch], lprx_en[ch], bias_sel[2*ch +: 2]};
    endfunction

    localparam int V_STBY = 5'b0_0_1_01;
    localparam int V_NORM = 5'b1_1_0_10;
    localparam int V_OFF  = 5'b0_0_0_00;

    task automatic t_reset();
        check("R9 ch0 outputs after reset", ch_view(0), V_STBY);
        check("R9 ch1 outputs after reset", ch_view(1), V_STBY);
    endtask

    task automatic t_normal_entry();
        stby_req[0] = 1'b0;
        tick(DLY);
        check("R8 ch0 tx still off one cycle early", ch_view(0), V_STBY);
        tick(1);
        check("R8 ch0 enters Normal on time", ch_view(0), V_NORM);
        check("R1 ch1 unaffected by ch0 request", ch_view(1), V_STBY);
    endtask

    task automatic t_rx_follow();
        bus_dom[0] = 1'b1; tick(1);
        check("R3 rx low on dominant", rx_out[0], 0);
        bus_dom[0] = 1'b0; tick(1);
        check("R3 rx high on recessive", rx_out[0], 1);
        wake_det[0] = 1'b1; tick(1);
        check("R3 wake flag ignored in Normal", rx_out[0], 1);
        wake_det[0] = 1'b0;
        stby_req[0] = 1'b1; tick(1);
        check("R1 ch0 back to Standby", ch_view(0), V_STBY);
    endtask

    task automatic t_wake_stby();
        wake_det[1] = 1'b1; bus_dom[1] = 1'b0; tick(1);
        check("R4 rx low on wake detect", rx_out[1], 0);
        tick(DLY + 4);
        check("R5 wake does not leave Standby", ch_view(1), V_STBY);
        wake_det[1] = 1'b0; tick(1);
        check("R4 rx high without wake", rx_out[1], 1);
    endtask

    task automatic t_restart();
        stby_req[1] = 1'b0; tick(5);
        stby_req[1] = 1'b1; tick(1);
        stby_req[1] = 1'b0; tick(DLY);
        check("R8 restart: no tx before full delay", ch_view(1), V_STBY);
        tick(1);
        check("R8 restart: Normal after full delay", ch_view(1), V_NORM);
    endtask

    task automatic t_core_uv();
        stby_req[0] = 1'b0; tick(DLY + 1);
        check("R6 precondition ch0 Normal", ch_view(0), V_NORM);
        core_uv = 1'b1; tick(1);
        check("R6 ch0 forced Standby", ch_view(0), V_STBY);
        check("R6 ch1 forced Standby", ch_view(1), V_STBY);
        tick(DLY + 4);
        check("R6 requests ignored during fault", ch_view(0), V_STBY);
        core_uv = 1'b0; tick(DLY);
        check("R6 full delay after recovery", ch_view(1), V_STBY);
        tick(1);
        check("R6 Normal after recovery delay", ch_view(1), V_NORM);
    endtask

    task automatic t_io_uv();
        bus_dom = '1; wake_det = '1;
        io_uv = 1'b1; tick(1);
        check("R7 ch0 disengaged", ch_view(0), V_OFF);
        check("R7 ch1 disengaged", ch_view(1), V_OFF);
        check("R7 rx held high", rx_out, 2'b11);
        stby_req = '1; tick(3);
        check("R7 stays off during fault", ch_view(0), V_OFF);
        io_uv = 1'b0; tick(1);
        check("R7 back to Standby on recovery", ch_view(1), V_STBY);
        check("R4 rx after recovery shows wake", rx_out, 2'b00);
    endtask

    initial begin
        tick(2);
        t_reset();
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_normal_entry();
        t_rx_follow();
        t_wake_stby();
        t_restart();
        t_core_uv();
        t_io_uv();
        if (!finished) begin
            finished = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule